// File: doc/BRIEF.md
# Occupancy-Balanced Fetch Thread Selector

In a simultaneous multithreaded core, this block decides which hardware thread the front end fetches from in each cycle. It keeps a program counter for each thread. It also keeps a count of each thread's instructions that have been fetched and not yet drained. Each cycle it considers the threads that are ready and not stalled, and grants the one with the fewest pending instructions. A thread that runs ahead therefore loses fetch slots to threads that hold fewer instructions in flight. When pending counts are equal, a rotating priority settles the choice, starting just after the thread granted most recently.

The front end reports how many instructions it took from the granted thread. The back end reports, per thread, how many instructions left the pipeline. A flush request clears a thread's occupancy and redirects its program counter. The outputs are combinational from the registered state and the current inputs. There are three of them: a fetch-valid flag, the granted thread id, and that thread's program counter.

Top module: `smt_fetch_sel`

## Requirements
- R1: A thread is eligible when its ready bit is 1 and its stall bit is 0. fetchValid is 1 exactly when at least one thread is eligible, and the granted thread is always eligible.
- R2: The granted thread has the smallest pending count among all eligible threads.
- R3: Among eligible threads with equal smallest count, priority rotates. The search starts at the thread after the last granted one (any cycle with fetchValid=1 records a grant) and wraps around. After reset, thread 0 has first priority.
- R4: While fetchValid is 1, fetchPc equals the granted thread's program counter. Every program counter resets to RESET_PC.
- R5: acceptValid=1 while fetchValid=1 adds acceptCnt to the granted thread's pending count. It also advances that thread's PC by acceptCnt*INSTR_BYTES on the next edge.
- R6: Field t of drainCnt (bits t*ACC_W upward, ACC_W wide) subtracts from thread t's count in the same cycle as any accept. The net result never goes below zero.
- R7: A pending count saturates at 2^CNT_W-1 and never wraps.
- R8: flushReq[t] clears thread t's count and loads its PC from field t of redirectPc (bits t*PC_W upward). It overrides any accept or drain for that thread in that cycle.
- R9: When no thread is eligible, fetchValid is 0, acceptValid is ignored, and no PC changes except by flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadReady | input | NUM_THREADS | Per-thread ready flag |
| threadStall | input | NUM_THREADS | Per-thread stall flag (e.g. long miss) |
| acceptValid | input | 1 | Front end took instructions from the granted thread |
| acceptCnt | input | ACC_W | Number of instructions taken |
| drainCnt | input | NUM_THREADS*ACC_W | Per-thread instructions leaving the pipeline |
| flushReq | input | NUM_THREADS | Per-thread flush |
| redirectPc | input | NUM_THREADS*PC_W | Per-thread redirect target |
| fetchValid | output | 1 | A thread is granted this cycle |
| fetchTid | output | TID_W | Granted thread id |
| fetchPc | output | PC_W | Granted thread's PC (zero when fetchValid is 0) |

## Verification
The assertions check on every cycle that:
- the grant goes to an eligible thread whenever one exists;
- no eligible thread holds fewer pending instructions than the granted one;
- a flush leaves a zero count and the redirect target;
- counts stay pinned at their bounds;
- program counters hold while nothing is granted.

Only the bench's scenarios can show the rotation order among tied threads, the exact PC advance per accepted instruction, and that saturation and the floor at zero leave the correct counts. The bench infers those counts from the grants that follow. A near-exhaustive pseudo-random sweep over a four-thread, three-bit-count configuration compares every cycle against an arithmetic model.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  // Strobes from the selector control to the per-thread datapath
  typedef struct packed {
    logic grantValid;  // some thread granted this cycle
    logic acceptFire;  // front end consumed instructions from the grant
  } fetchStrobes_t;
endpackage

// File: rtl/smt_fetch_ctrl.sv
module smt_fetch_ctrl
  import smt_fetch_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int TID_W = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_THREADS-1:0]            threadReady,
  input  logic [NUM_THREADS-1:0]            threadStall,
  input  logic                              acceptValid,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] pendCnt,
  output fetchStrobes_t                     strobes,
  output logic [TID_W-1:0]                  grantTid
);
  logic [NUM_THREADS-1:0] eligible;
  logic [TID_W-1:0]       lastGrant;
  logic                   found;
  logic [TID_W-1:0]       bestTid;
  logic [CNT_W-1:0]       bestCnt;

  // Walk threads in rotating order; strict less-than keeps the earliest on ties
  always_comb begin
    eligible = threadReady & ~threadStall;
    found    = 1'b0;
    bestTid  = '0;
    bestCnt  = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      int idx;
      logic [TID_W-1:0] tIdx;
      idx  = (int'(lastGrant) + 1 + i) % NUM_THREADS;
      tIdx = TID_W'(idx);
      if (eligible[tIdx] && (!found || pendCnt[tIdx] < bestCnt)) begin
        found   = 1'b1;
        bestTid = tIdx;
        bestCnt = pendCnt[tIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      lastGrant <= TID_W'(NUM_THREADS - 1);
    else if (found) lastGrant <= bestTid;
  end

  assign strobes.grantValid = found;
  assign strobes.acceptFire = found & acceptValid;
  assign grantTid           = bestTid;
endmodule

// File: rtl/smt_fetch_dp.sv
module smt_fetch_dp
  import smt_fetch_pkg::*;
#(
  parameter int          NUM_THREADS = 8,
  parameter int          CNT_W = 6,
  parameter int          PC_W = 32,
  parameter int          ACC_W = 3,
  parameter int          TID_W = 3,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  fetchStrobes_t                     strobes,
  input  logic [TID_W-1:0]                  grantTid,
  input  logic [ACC_W-1:0]                  acceptCnt,
  input  logic [NUM_THREADS*ACC_W-1:0]      drainCnt,
  input  logic [NUM_THREADS-1:0]            flushReq,
  input  logic [NUM_THREADS*PC_W-1:0]       redirectPc,
  output logic [NUM_THREADS-1:0][CNT_W-1:0] pendCnt,
  output logic [NUM_THREADS-1:0][PC_W-1:0]  pcVec,
  output logic [PC_W-1:0]                   fetchPc
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

  logic [PC_W-1:0] pcStep;
  assign pcStep = PC_W'(acceptCnt) * PC_W'(INSTR_BYTES);

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thread
    logic             incSel;
    logic [SUM_W-1:0] sumC, decC, netC, satC;

    assign incSel = strobes.acceptFire && (grantTid == TID_W'(g));

    // Add fetched, subtract drained, clamp to [0, CNT_MAX]
    always_comb begin
      sumC = SUM_W'(pendCnt[g]) + (incSel ? SUM_W'(acceptCnt) : '0);
      decC = SUM_W'(drainCnt[g*ACC_W +: ACC_W]);
      netC = (sumC >= decC) ? (sumC - decC) : '0;
      satC = (netC > CNT_MAX) ? CNT_MAX : netC;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCnt[g] <= '0;
        pcVec[g]   <= PC_W'(RESET_PC);
      end else if (flushReq[g]) begin
        pendCnt[g] <= '0;
        pcVec[g]   <= redirectPc[g*PC_W +: PC_W];
      end else begin
        pendCnt[g] <= satC[CNT_W-1:0];
        if (incSel) pcVec[g] <= pcVec[g] + pcStep;
      end
    end
  end

  assign fetchPc = strobes.grantValid ? pcVec[grantTid] : '0;
endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
  import smt_fetch_pkg::*;
#(
  parameter int          NUM_THREADS = 8,
  parameter int          CNT_W = 6,
  parameter int          PC_W = 32,
  parameter int          FETCH_W = 4,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int         ACC_W = $clog2(FETCH_W + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_THREADS-1:0]       threadReady,
  input  logic [NUM_THREADS-1:0]       threadStall,
  input  logic                         acceptValid,
  input  logic [ACC_W-1:0]             acceptCnt,
  input  logic [NUM_THREADS*ACC_W-1:0] drainCnt,
  input  logic [NUM_THREADS-1:0]       flushReq,
  input  logic [NUM_THREADS*PC_W-1:0]  redirectPc,
  output logic                         fetchValid,
  output logic [TID_W-1:0]             fetchTid,
  output logic [PC_W-1:0]              fetchPc
);
  fetchStrobes_t                     strobes;
  logic [TID_W-1:0]                  grantTid;
  logic [NUM_THREADS-1:0][CNT_W-1:0] pendCnt;
  logic [NUM_THREADS-1:0][PC_W-1:0]  pcVec;

  smt_fetch_ctrl #(
    .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .threadReady(threadReady), .threadStall(threadStall),
    .acceptValid(acceptValid), .pendCnt(pendCnt), .strobes(strobes), .grantTid(grantTid)
  );

  smt_fetch_dp #(
    .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .PC_W(PC_W), .ACC_W(ACC_W),
    .TID_W(TID_W), .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grantTid(grantTid),
    .acceptCnt(acceptCnt), .drainCnt(drainCnt), .flushReq(flushReq),
    .redirectPc(redirectPc), .pendCnt(pendCnt), .pcVec(pcVec), .fetchPc(fetchPc)
  );

  assign fetchValid = strobes.grantValid;
  assign fetchTid   = grantTid;
endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk #(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W = 6,
  parameter int PC_W = 32,
  parameter int ACC_W = 3,
  parameter int TID_W = 3
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [NUM_THREADS-1:0]            threadReady,
  input logic [NUM_THREADS-1:0]            threadStall,
  input logic                              acceptValid,
  input logic [NUM_THREADS*ACC_W-1:0]      drainCnt,
  input logic [NUM_THREADS-1:0]            flushReq,
  input logic [NUM_THREADS*PC_W-1:0]       redirectPc,
  input logic                              fetchValid,
  input logic [TID_W-1:0]                  fetchTid,
  input logic [NUM_THREADS-1:0][CNT_W-1:0] pendCnt,
  input logic [NUM_THREADS-1:0][PC_W-1:0]  pcVec
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (threadReady[fetchTid] && !threadStall[fetchTid]));

  assert_valid_when_any_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((threadReady & ~threadStall) != '0) |-> fetchValid);

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && flushReq == '0) |=> $stable(pcVec));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    assert_min_pick_R2: assert property (@(posedge clk) disable iff (!rstN)
      (fetchValid && threadReady[g] && !threadStall[g]) |-> (pendCnt[fetchTid] <= pendCnt[g]));

    assert_flush_load_R8: assert property (@(posedge clk) disable iff (!rstN)
      flushReq[g] |=> (pendCnt[g] == '0 && pcVec[g] == $past(redirectPc[g*PC_W +: PC_W])));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
      (pendCnt[g] == CNT_MAX && !flushReq[g] && drainCnt[g*ACC_W +: ACC_W] == '0)
      |=> (pendCnt[g] == CNT_MAX));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      (pendCnt[g] == '0 && !(fetchValid && acceptValid && fetchTid == TID_W'(g)))
      |=> (pendCnt[g] == '0));
  end
endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(
  .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .PC_W(PC_W), .ACC_W(ACC_W), .TID_W(TID_W)
) chk_i (
  .clk(clk), .rstN(rstN), .threadReady(threadReady), .threadStall(threadStall),
  .acceptValid(acceptValid), .drainCnt(drainCnt), .flushReq(flushReq),
  .redirectPc(redirectPc), .fetchValid(fetchValid), .fetchTid(fetchTid),
  .pendCnt(pendCnt), .pcVec(pcVec)
);

// File: tb/smt_fetch_sel_tb_top.sv
`timescale 1ns/1ps
module smt_fetch_sel_tb_top;
  localparam int NT = 4;
  localparam int CW = 3;
  localparam int PW = 16;
  localparam int FW = 2;
  localparam int AW = 2;
  localparam int TW = 2;
  localparam int IB = 4;
  localparam logic [31:0] RPC = 32'h0100;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NT-1:0] rdy = '0, stl = '0, flush = '0;
  logic accV = 1'b0;
  logic [AW-1:0] accC = '0;
  logic [NT*AW-1:0] drn = '0;
  logic [NT*PW-1:0] redir = '0;
  logic fetchValid;
  logic [TW-1:0] fetchTid;
  logic [PW-1:0] fetchPc;

  int checks = 0, fails = 0;
  bit done = 0;
  int mCnt[NT];
  logic [PW-1:0] mPc[NT];
  int mLast;
  logic [31:0] seed = 32'h1234_5677;

  always #2.5 clk = ~clk;

  smt_fetch_sel #(
    .NUM_THREADS(NT), .CNT_W(CW), .PC_W(PW), .FETCH_W(FW),
    .INSTR_BYTES(IB), .RESET_PC(RPC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .threadReady(rdy), .threadStall(stl),
    .acceptValid(accV), .acceptCnt(accC), .drainCnt(drn), .flushReq(flush),
    .redirectPc(redir), .fetchValid(fetchValid), .fetchTid(fetchTid), .fetchPc(fetchPc)
  );

  // Expected grant from the requirements: min count, rotating tie-break
  function automatic int pick();
    int best = -1;
    for (int i = 0; i < NT; i++) begin
      int t = (mLast + 1 + i) % NT;
      if (rdy[t] && !stl[t] && (best < 0 || mCnt[t] < mCnt[best])) best = t;
    end
    return best;
  endfunction

  task automatic chk(input string tag, input bit ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs already set at a negedge; compare, then advance model on the edge
  task automatic step(input string tag);
    int e;
    int nCnt[NT];
    logic [PW-1:0] nPc[NT];
    #1;
    e = pick();
    chk({tag, " fetchValid"}, fetchValid == (e >= 0), int'(fetchValid), int'(e >= 0));
    if (e >= 0) begin
      chk({tag, " fetchTid"}, fetchTid == TW'(e), int'(fetchTid), e);
      chk({tag, " fetchPc"}, fetchPc == mPc[e], int'(fetchPc), int'(mPc[e]));
    end
    for (int t = 0; t < NT; t++) begin
      int inc = (e == t && accV) ? int'(accC) : 0;
      int n = mCnt[t] + inc - int'(drn[t*AW +: AW]);
      if (n < 0) n = 0;
      if (n > CMAX) n = CMAX;
      nCnt[t] = n;
      nPc[t] = (e == t && accV) ? mPc[t] + PW'(inc * IB) : mPc[t];
      if (flush[t]) begin
        nCnt[t] = 0;
        nPc[t] = redir[t*PW +: PW];
      end
    end
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin
      mCnt[t] = nCnt[t];
      mPc[t] = nPc[t];
    end
    if (e >= 0) mLast = e;
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      mCnt[t] = 0;
      mPc[t] = PW'(RPC);
    end
    mLast = NT - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R4: reset PC and thread 0 first; R3: rotation over equal counts
    rdy = '1;
    step("R4 reset");
    repeat (4) step("R3 rotation");

    // R5: accepted counts raise occupancy and advance the PC
    accV = 1'b1; accC = 2'd2; step("R5");
    accC = 2'd1;              step("R5");
    accC = 2'd2;              step("R5");
    accV = 1'b0;
    step("R2 min count"); step("R2 min count");

    // R1/R9: all stalled, accept ignored and PCs held
    stl = '1; accV = 1'b1; accC = 2'd2;
    step("R9 none eligible"); step("R9 none eligible");
    stl = 4'b1011; step("R1 single eligible");
    stl = '0;

    // R6: drain together with accept, then drain to the floor
    drn = {4{2'd1}}; repeat (4) step("R6 net");
    accV = 1'b0; drn = {4{2'd2}}; repeat (3) step("R6 floor");
    drn = '0;

    // R8: flush overrides accept on the granted thread
    flush = 4'b0010; redir = '0; redir[1*PW +: PW] = 16'h2000;
    accV = 1'b1; accC = 2'd2; rdy = '1; step("R8 flush");
    flush = '0; accV = 1'b0; rdy = 4'b0010; step("R8 redirect");

    // R7: saturate thread 0, drain 6, then tie with thread 1 at count 1
    flush = '1; redir = {4{16'h0300}}; step("R8 flush all");
    flush = '0;
    rdy = 4'b0010; accV = 1'b1; accC = 2'd1; step("R7 setup");
    rdy = 4'b0001; accC = 2'd2; repeat (5) step("R7 saturate");
    accV = 1'b0; rdy = '0; drn = '0; drn[1:0] = 2'd2; repeat (3) step("R7 drain");
    drn = '0; rdy = 4'b0011; step("R7 tie after saturation");
    step("R7 follow");

    // Near-exhaustive sweep against the model (R2, R3, R5, R6, R8 mixed)
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      rdy = a[3:0];
      stl = a[7:4] & a[11:8];
      accV = a[12];
      accC = a[14:13];
      drn = b[7:0] & a[23:16];
      flush = b[11:8] & b[15:12] & a[27:24];
      redir = {b[31:16], a[31:16], b[31:16] ^ a[15:0], a[31:16] ^ b[15:0]};
      step("R2 sweep");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule